// File: doc/BRIEF.md
# Character I/O and Interrupt Entry Unit

This unit sits beside the control sequencer of a small 16-bit accumulator machine. It holds the byte-wide character ports, their ready flags, the interrupt enable and the interrupt-cycle flag. It decodes the six I/O operations carried in the select bits of the instruction register when the sequencer reports an I/O instruction in timing slot 3. For each operation it loads the accumulator's low byte, updates the output port, requests a program-counter skip or changes the enable flag.

A device writes a received byte with a single-cycle strobe. A device reports that it has taken the output byte with a single-cycle acknowledge. While interrupts are enabled and either flag is raised, the unit arms its interrupt-cycle flag at any edge outside slots 0 to 2. While that flag is set, the normal fetch is suppressed. The unit then issues a three-slot sequence that stores the program counter at address 0 and resumes at address 1, where the service branch lives.

Top module: `pio_irq_unit`

## Requirements
- R1: After reset the input flag is 0, the output flag is 1, the interrupt enable is 0, the interrupt-cycle flag is 0, `fetch_ok` is 1, and both character registers are 0.
- R2: An I/O instruction executes only when `dec_d7`, `ir_ind` and `sc_val`=3 are all true in the same cycle. When it executes, `sc_clr` is high, whatever the select bits are.
- R3: With `io_sel[5]` (input), `acc_ld` is high and `acc_ld_data` shows the input register, and the input flag is 0 after the edge.
- R4: With `io_sel[4]` (output), the output register takes `acc_lo` at the edge and the output flag clears.
- R5: With `io_sel[3]`, `pc_inc` is high when the input flag is 1. With `io_sel[2]`, `pc_inc` is high when the output flag is 1. Otherwise the skip stays low.
- R6: `io_sel[1]` sets the interrupt enable and `io_sel[0]` clears it. When both are set in one instruction, the clear wins.
- R7: `dev_in_stb` loads `dev_in_data` into the input register and sets the input flag. `dev_out_ack` sets the output flag. A device event wins over an instruction clearing the same flag in the same cycle.
- R8: The interrupt-cycle flag sets at an edge only when the enable is 1, at least one flag is 1, and `sc_val` is not 0, 1 or 2. `fetch_ok` is its inverse.
- R9: In the interrupt cycle, slot 0 raises `ar_clr` and copies `pc_val` into the save register (`mem_wdata`). Slot 1 raises `mem_we` and `pc_clr`.
- R10: In the interrupt cycle, slot 2 raises `pc_inc` and `sc_clr`, and at that edge the interrupt enable and the interrupt-cycle flag both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_val | input | SC_W | Sequence counter value (timing slot) |
| dec_d7 | input | 1 | Opcode decode 7 (non-memory instruction) |
| ir_ind | input | 1 | Instruction mode bit |
| io_sel | input | 6 | Select bits: [5] input, [4] output, [3] skip-in, [2] skip-out, [1] enable on, [0] enable off |
| acc_lo | input | DATA_W | Accumulator low byte |
| pc_val | input | ADDR_W | Program counter value |
| dev_in_stb | input | 1 | Device byte-ready strobe |
| dev_in_data | input | DATA_W | Device byte |
| dev_out_ack | input | 1 | Device took the output byte |
| dev_out_data | output | DATA_W | Output character register |
| in_flag | output | 1 | Input ready flag |
| out_flag | output | 1 | Output ready flag |
| irq_en | output | 1 | Interrupt enable |
| irq_cyc | output | 1 | Interrupt-cycle flag |
| fetch_ok | output | 1 | Normal fetch allowed |
| acc_ld | output | 1 | Load accumulator low byte |
| acc_ld_data | output | DATA_W | Byte for the accumulator (input register) |
| pc_inc | output | 1 | Increment program counter |
| pc_clr | output | 1 | Clear program counter |
| ar_clr | output | 1 | Clear address register |
| sc_clr | output | 1 | Clear sequence counter |
| mem_we | output | 1 | Write save register to memory |
| mem_wdata | output | ADDR_W | Saved program counter |

## Verification
The properties assume that the surrounding sequencer steps `sc_val` through 0, 1 and 2 after the interrupt flag sets. They also assume that `pc_val` is a plain value sampled at the slot-0 edge, and that the device strobes are single-cycle pulses. The stimulus drives `sc_val` directly, so it walks slots 0, 1 and 2 in order every time the flag rises. It also raises each strobe for exactly one cycle. The decode table is applied while reset holds the flags at known values, so each combinational result there depends on the select pattern alone.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  localparam int unsigned IO_SEL_W  = 6;
  localparam int unsigned NUM_SLOTS = 4;

  typedef struct packed {
    logic inp;
    logic outp;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_cmd_t;
endpackage

// File: rtl/pio_slot_dec.sv
module pio_slot_dec #(
  parameter int unsigned SC_W  = 4,
  parameter int unsigned NSLOT = 4
) (
  input  logic [SC_W-1:0]  sc_val,
  output logic [NSLOT-1:0] slot
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slot[k] = (sc_val == SC_W'(k));
  end
endmodule

// File: rtl/pio_dev_regs.sv
module pio_dev_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ack,
  input  logic              do_inp,
  input  logic              do_out,
  input  logic [DATA_W-1:0] acc_lo,
  output logic [DATA_W-1:0] inpr_q,
  output logic [DATA_W-1:0] outr_q,
  output logic              fgi_q,
  output logic              fgo_q
);
  logic fgi_d, fgo_d;

  // device event is applied last so it has priority over an instruction clear
  always_comb begin
    fgi_d = fgi_q;
    if (do_inp) fgi_d = 1'b0;
    if (in_stb) fgi_d = 1'b1;
    fgo_d = fgo_q;
    if (do_out)  fgo_d = 1'b0;
    if (out_ack) fgo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inpr_q <= '0;
      outr_q <= '0;
      fgi_q  <= 1'b0;
      fgo_q  <= 1'b1;
    end else begin
      if (in_stb) inpr_q <= in_data;
      if (do_out) outr_q <= acc_lo;
      fgi_q <= fgi_d;
      fgo_q <= fgo_d;
    end
  end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot,
  input  logic                 io_exec,
  input  io_cmd_t              cmd,
  input  logic                 fgi,
  input  logic                 fgo,
  input  logic [ADDR_W-1:0]    pc_val,
  output logic                 ien_q,
  output logic                 r_q,
  output logic [ADDR_W-1:0]    tr_q,
  output logic                 rt0,
  output logic                 rt1,
  output logic                 rt2
);
  logic ien_d, r_d, tr_en, arm;

  assign rt0   = r_q & slot[0];
  assign rt1   = r_q & slot[1];
  assign rt2   = r_q & slot[2];
  assign tr_en = rt0;
  assign arm   = ien_q & (fgi | fgo) & ~(slot[0] | slot[1] | slot[2]);

  always_comb begin
    ien_d = ien_q;
    if (io_exec && cmd.ion) ien_d = 1'b1;
    if (io_exec && cmd.iof) ien_d = 1'b0;
    if (rt2)                ien_d = 1'b0;
    r_d = r_q;
    if (arm) r_d = 1'b1;
    if (rt2) r_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      r_q   <= 1'b0;
      tr_q  <= '0;
    end else begin
      ien_q <= ien_d;
      r_q   <= r_d;
      if (tr_en) tr_q <= pc_val;
    end
  end
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit
  import pio_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SC_W-1:0]   sc_val,
  input  logic              dec_d7,
  input  logic              ir_ind,
  input  logic [5:0]        io_sel,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [ADDR_W-1:0] pc_val,
  input  logic              dev_in_stb,
  input  logic [DATA_W-1:0] dev_in_data,
  input  logic              dev_out_ack,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              in_flag,
  output logic              out_flag,
  output logic              irq_en,
  output logic              irq_cyc,
  output logic              fetch_ok,
  output logic              acc_ld,
  output logic [DATA_W-1:0] acc_ld_data,
  output logic              pc_inc,
  output logic              pc_clr,
  output logic              ar_clr,
  output logic              sc_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wdata
);
  logic [1:0]           rst_pipe;
  logic                 rst_sync_n;
  logic [NUM_SLOTS-1:0] slot;
  io_cmd_t              cmd;
  logic                 io_exec;
  logic                 rt0, rt1, rt2;
  logic [DATA_W-1:0]    inpr_q;
  logic                 skip_io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pio_slot_dec #(.SC_W(SC_W), .NSLOT(NUM_SLOTS)) u_slot (
    .sc_val (sc_val),
    .slot   (slot)
  );

  assign cmd     = io_cmd_t'(io_sel);
  assign io_exec = dec_d7 & ir_ind & slot[3];

  pio_dev_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_stb  (dev_in_stb),
    .in_data (dev_in_data),
    .out_ack (dev_out_ack),
    .do_inp  (io_exec & cmd.inp),
    .do_out  (io_exec & cmd.outp),
    .acc_lo  (acc_lo),
    .inpr_q  (inpr_q),
    .outr_q  (dev_out_data),
    .fgi_q   (in_flag),
    .fgo_q   (out_flag)
  );

  pio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .slot    (slot),
    .io_exec (io_exec),
    .cmd     (cmd),
    .fgi     (in_flag),
    .fgo     (out_flag),
    .pc_val  (pc_val),
    .ien_q   (irq_en),
    .r_q     (irq_cyc),
    .tr_q    (mem_wdata),
    .rt0     (rt0),
    .rt1     (rt1),
    .rt2     (rt2)
  );

  assign skip_io     = io_exec & ((cmd.ski & in_flag) | (cmd.sko & out_flag));
  assign fetch_ok    = ~irq_cyc;
  assign acc_ld      = io_exec & cmd.inp;
  assign acc_ld_data = inpr_q;
  assign pc_inc      = skip_io | rt2;
  assign pc_clr      = rt1;
  assign ar_clr      = rt0;
  assign sc_clr      = io_exec | rt2;
  assign mem_we      = rt1;
endmodule

// File: rtl/pio_irq_chk.sv
module pio_irq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [SC_W-1:0]   sc_val,
  input logic              dec_d7,
  input logic              ir_ind,
  input logic [5:0]        io_sel,
  input logic [DATA_W-1:0] acc_lo,
  input logic [ADDR_W-1:0] pc_val,
  input logic              dev_in_stb,
  input logic [DATA_W-1:0] dev_in_data,
  input logic              dev_out_ack,
  input logic [DATA_W-1:0] dev_out_data,
  input logic              in_flag,
  input logic              out_flag,
  input logic              irq_en,
  input logic              irq_cyc,
  input logic              acc_ld,
  input logic [DATA_W-1:0] acc_ld_data,
  input logic              sc_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_wdata
);
  localparam logic [SC_W-1:0] S0 = SC_W'(0);
  localparam logic [SC_W-1:0] S1 = SC_W'(1);
  localparam logic [SC_W-1:0] S2 = SC_W'(2);
  localparam logic [SC_W-1:0] S3 = SC_W'(3);

  // R2
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(dec_d7 && ir_ind) && !irq_cyc) |-> !sc_clr);

  // R3
  inp_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_ld && !dev_in_stb) |=> !in_flag);

  // R4
  out_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_d7 && ir_ind && sc_val == S3 && io_sel[4])
      |=> (dev_out_data == $past(acc_lo)) && (out_flag == $past(dev_out_ack)));

  // R7
  dev_in_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dev_in_stb |=> in_flag && (acc_ld_data == $past(dev_in_data)));

  // R8
  arm_cond_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_cyc) |-> $past(irq_en && (in_flag || out_flag) && sc_val > S2));

  // R9
  save_pc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_cyc && sc_val == S0) |=> mem_wdata == $past(pc_val));

  // R9
  mem_we_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> (irq_cyc && sc_val == S1));

  // R10
  irq_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_cyc && sc_val == S2) |=> (!irq_cyc && !irq_en));
endmodule

bind pio_irq_unit pio_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (.*);

// File: tb/sim_pio_irq_unit.sv
module sim_pio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sc_val;
  logic        dec_d7, ir_ind;
  logic [5:0]  io_sel;
  logic [7:0]  acc_lo;
  logic [11:0] pc_val;
  logic        dev_in_stb;
  logic [7:0]  dev_in_data;
  logic        dev_out_ack;
  logic [7:0]  dev_out_data;
  logic        in_flag, out_flag, irq_en, irq_cyc, fetch_ok;
  logic        acc_ld;
  logic [7:0]  acc_ld_data;
  logic        pc_inc, pc_clr, ar_clr, sc_clr, mem_we;
  logic [11:0] mem_wdata;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pio_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .sc_val(sc_val), .dec_d7(dec_d7), .ir_ind(ir_ind),
    .io_sel(io_sel), .acc_lo(acc_lo), .pc_val(pc_val), .dev_in_stb(dev_in_stb),
    .dev_in_data(dev_in_data), .dev_out_ack(dev_out_ack), .dev_out_data(dev_out_data),
    .in_flag(in_flag), .out_flag(out_flag), .irq_en(irq_en), .irq_cyc(irq_cyc),
    .fetch_ok(fetch_ok), .acc_ld(acc_ld), .acc_ld_data(acc_ld_data), .pc_inc(pc_inc),
    .pc_clr(pc_clr), .ar_clr(ar_clr), .sc_clr(sc_clr), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  // {sc[14:11], d7[10], ind[9], sel[8:3], pc_inc[2], sc_clr[1], acc_ld[0]}
  // flags at reset values: input flag 0, output flag 1
  localparam logic [14:0] VEC [8] = '{
    {4'd3, 1'b1, 1'b1, 6'b001000, 3'b010},
    {4'd3, 1'b1, 1'b1, 6'b000100, 3'b110},
    {4'd3, 1'b1, 1'b1, 6'b100000, 3'b011},
    {4'd2, 1'b1, 1'b1, 6'b100000, 3'b000},
    {4'd3, 1'b1, 1'b0, 6'b100000, 3'b000},
    {4'd3, 1'b0, 1'b1, 6'b100000, 3'b000},
    {4'd3, 1'b1, 1'b1, 6'b000000, 3'b010},
    {4'd4, 1'b1, 1'b1, 6'b000100, 3'b000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setin(input logic [3:0] sc, input logic d7, input logic ind, input logic [5:0] sel);
    sc_val = sc; dec_d7 = d7; ir_ind = ind; io_sel = sel;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; setin(4'd0, 1'b0, 1'b0, 6'd0);
    acc_lo = 8'h00; pc_val = 12'h000;
    dev_in_stb = 1'b0; dev_in_data = 8'h00; dev_out_ack = 1'b0;
    tick();
    // R2 R3 R5 decode table, walked with the flags held at reset values
    for (int i = 0; i < 8; i++) begin
      setin(VEC[i][14:11], VEC[i][10], VEC[i][9], VEC[i][8:3]);
      #2;
      chk($sformatf("R5 table %0d pc_inc", i), 32'(pc_inc), 32'(VEC[i][2]));
      chk($sformatf("R2 table %0d sc_clr", i), 32'(sc_clr), 32'(VEC[i][1]));
      chk($sformatf("R3 table %0d acc_ld", i), 32'(acc_ld), 32'(VEC[i][0]));
      tick();
    end
    setin(4'd0, 1'b0, 1'b0, 6'd0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 in_flag", 32'(in_flag), 0);
    chk("R1 out_flag", 32'(out_flag), 1);
    chk("R1 irq_en", 32'(irq_en), 0);
    chk("R1 irq_cyc", 32'(irq_cyc), 0);
    chk("R1 fetch_ok", 32'(fetch_ok), 1);
    chk("R1 outr", 32'(dev_out_data), 0);
    chk("R1 inpr", 32'(acc_ld_data), 0);

    // R7 device byte arrives
    dev_in_stb = 1'b1; dev_in_data = 8'hA5;
    tick(); dev_in_stb = 1'b0;
    chk("R7 in_flag set", 32'(in_flag), 1);

    // R5 skip on input flag
    setin(4'd3, 1'b1, 1'b1, 6'b001000); #1;
    chk("R5 skip-in", 32'(pc_inc), 1);
    tick();

    // R3 input to accumulator
    setin(4'd3, 1'b1, 1'b1, 6'b100000); #1;
    chk("R3 acc_ld", 32'(acc_ld), 1);
    chk("R3 data", 32'(acc_ld_data), 32'h0A5);
    tick(); setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R3 flag clear", 32'(in_flag), 0);

    // R4 output from accumulator
    acc_lo = 8'h3C;
    setin(4'd3, 1'b1, 1'b1, 6'b010000);
    tick(); setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R4 outr", 32'(dev_out_data), 32'h03C);
    chk("R4 flag clear", 32'(out_flag), 0);
    setin(4'd3, 1'b1, 1'b1, 6'b000100); #1;
    chk("R5 no skip-out", 32'(pc_inc), 0);
    tick();

    // R6 enable on; R8 no flags raised
    setin(4'd3, 1'b1, 1'b1, 6'b000010);
    tick(); setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R6 ion", 32'(irq_en), 1);
    setin(4'd5, 1'b0, 1'b0, 6'd0);
    tick();
    chk("R8 no flag", 32'(irq_cyc), 0);

    // R7 ack; R8 slot guard then arm
    sc_val = 4'd1; dev_out_ack = 1'b1;
    tick(); dev_out_ack = 1'b0;
    chk("R7 out_flag set", 32'(out_flag), 1);
    tick();
    chk("R8 slot guard", 32'(irq_cyc), 0);
    sc_val = 4'd4;
    tick();
    chk("R8 armed", 32'(irq_cyc), 1);
    chk("R8 fetch_ok", 32'(fetch_ok), 0);

    // R9 R10 interrupt cycle
    pc_val = 12'h2A5; sc_val = 4'd0; #1;
    chk("R9 ar_clr", 32'(ar_clr), 1);
    tick();
    chk("R9 saved pc", 32'(mem_wdata), 32'h2A5);
    sc_val = 4'd1; #1;
    chk("R9 mem_we", 32'(mem_we), 1);
    chk("R9 pc_clr", 32'(pc_clr), 1);
    tick();
    sc_val = 4'd2; #1;
    chk("R10 pc_inc", 32'(pc_inc), 1);
    chk("R10 sc_clr", 32'(sc_clr), 1);
    tick(); sc_val = 4'd0;
    chk("R10 ien clear", 32'(irq_en), 0);
    chk("R10 r clear", 32'(irq_cyc), 0);

    // R8 enable off blocks arming
    sc_val = 4'd6;
    tick();
    chk("R8 needs enable", 32'(irq_cyc), 0);

    // R6 on+off together: off wins (the edge before arms since enable was 0)
    setin(4'd3, 1'b1, 1'b1, 6'b000010);
    tick();
    setin(4'd3, 1'b1, 1'b1, 6'b000011);
    tick(); setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R6 off wins", 32'(irq_en), 0);
    chk("R8 armed at slot 3", 32'(irq_cyc), 1);
    pc_val = 12'h017;
    tick(); sc_val = 4'd1; tick(); sc_val = 4'd2; tick(); sc_val = 4'd0;
    chk("R10 exit", 32'(irq_cyc), 0);
    chk("R9 saved pc 2", 32'(mem_wdata), 32'h017);

    // R7 strobe wins over input clear
    setin(4'd3, 1'b1, 1'b1, 6'b100000);
    dev_in_stb = 1'b1; dev_in_data = 8'h5A; #1;
    chk("R7 old byte", 32'(acc_ld_data), 32'h0A5);
    tick(); dev_in_stb = 1'b0; setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R7 strobe wins", 32'(in_flag), 1);
    setin(4'd3, 1'b1, 1'b1, 6'b100000); #1;
    chk("R7 new byte", 32'(acc_ld_data), 32'h05A);
    tick(); setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R3 flag clear 2", 32'(in_flag), 0);

    // R7 ack wins over output clear
    acc_lo = 8'h81;
    setin(4'd3, 1'b1, 1'b1, 6'b010000); dev_out_ack = 1'b1;
    tick(); dev_out_ack = 1'b0; setin(4'd0, 1'b0, 1'b0, 6'd0);
    chk("R4 outr 2", 32'(dev_out_data), 32'h081);
    chk("R7 ack wins", 32'(out_flag), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule